// File: doc/BRIEF.md
# Dual-Port DRAM Arbiter with Relocatable Bus Window

This block shares a single on-board dynamic RAM array between two masters. The first is the local 16-bit processor, which always sees the array at address zero. The second is an external multi-master system bus, which sees the array at a base that can be placed on any 8 KiB boundary of a 20-bit space. The block also generates DRAM refresh cycles from an internal interval counter. Refresh always wins arbitration, the local processor comes next, and the system bus comes last. Arbitration is decided only between RAM cycles, so a cycle that has started always runs to the end.

On the bus side, a configurable contiguous run of 8 KiB segments can be hidden. A bus access that falls in a hidden segment, or outside the window, is left untouched, and the bus fabric's own timeout deals with it. Bus transfers can be bytes or words. Byte data travels in the low eight bits of the bus data, and the block steers it onto the RAM byte lane that address bit 0 selects.

The array is 32 KiB by default. Setting `BIG_ARRAY` gives 64 KiB, which is eight segments instead of four. Each master holds its request until it sees its one-clock acknowledge, and drops the request in that same clock.

Top module: `shared_ram_arbiter`

## Requirements
- R1: During and right after reset, no RAM cycle is active (`ram_cs` low) and both acknowledges are low.
- R2: A refresh becomes due every `REFRESH_INTERVAL` clocks. At the next arbitration point it is granted ahead of any pending local or bus request. A refresh cycle raises `ram_refresh` and `ram_cs`, never writes (`ram_we` low, `ram_be` = 00), and acknowledges nobody. Successive refresh starts are therefore never more than `REFRESH_INTERVAL + CYCLE_CLKS + 2` clocks apart.
- R3: During a refresh cycle, `ram_addr` carries the refresh row, zero-extended. The row advances by one, modulo 2^`ROW_W`, from one refresh to the next.
- R4: When both a local request and a bus request are pending at an arbitration point and no refresh is due, the local request is served first. Every RAM cycle holds `ram_cs` high for exactly `CYCLE_CLKS` clocks and is never cut short.
- R5: A local access is served only when its byte address is below the array size, i.e. bits 19..15 are zero in the 32 KiB build. The RAM word address is `loc_addr[15:1]`, with `ram_be` = 11. Any other local address gets no acknowledge and no RAM cycle.
- R6: A bus byte address A is in the window when (A[19:13] − `cfg_base`) mod 128 is below the segment count (4 by default). The RAM word address is then {that segment index, A[12:1]}. An address outside the window gets no acknowledge and no RAM cycle.
- R7: While `cfg_prot_en` is high, any in-window bus access whose segment index lies in `cfg_prot_lo`..`cfg_prot_hi` inclusive gets no acknowledge and no RAM cycle. When `cfg_prot_en` is low, the same access is served.
- R8: For a bus byte transfer (`bus_byte` = 1), A[0] = 0 selects the low lane (`ram_be` = 01) and A[0] = 1 the high lane (`ram_be` = 10). Write data `bus_wdata[7:0]` appears on both lanes of `ram_wdata`. A byte read returns the selected lane in `bus_rdata[7:0]` with the upper byte zero. A bus word transfer uses `ram_be` = 11.
- R9: An acknowledge is a one-clock pulse. It occurs in the clock right after `ram_cs` falls at the end of that master's data cycle, and the read data is valid on the master's read-data port while the acknowledge is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | 7 | Bus window base, counted in 8 KiB boundaries |
| cfg_prot_en | input | 1 | Enables segment hiding |
| cfg_prot_lo | input | 3 | First hidden segment index |
| cfg_prot_hi | input | 3 | Last hidden segment index |
| loc_req | input | 1 | Local processor request |
| loc_we | input | 1 | Local write (1) or read (0) |
| loc_addr | input | 19 | Local byte address bits 19..1 |
| loc_wdata | input | 16 | Local write word |
| loc_rdata | output | 16 | Local read word |
| loc_ack | output | 1 | Local completion pulse |
| bus_req | input | 1 | System bus request |
| bus_we | input | 1 | Bus write (1) or read (0) |
| bus_byte | input | 1 | Bus byte transfer (1) or word (0) |
| bus_addr | input | 20 | Bus byte address |
| bus_wdata | input | 16 | Bus write data (bytes in bits 7..0) |
| bus_rdata | output | 16 | Bus read data |
| bus_ack | output | 1 | Bus completion pulse |
| ram_cs | output | 1 | RAM cycle active |
| ram_refresh | output | 1 | Current cycle is a refresh |
| ram_we | output | 1 | RAM write strobe |
| ram_be | output | 2 | RAM byte-lane enables |
| ram_addr | output | 15 | RAM word address or refresh row |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data |

## Verification
The hardest situation to reach is a refresh falling due at an arbitration point while the other master is also waiting. Refresh is internal, and a single master drops its request during its acknowledge clock, so refresh would otherwise always find a free slot and its priority would never be tested. The bench drives the local and bus ports back-to-back in parallel for well over two refresh intervals. That way one master is pending at every arbitration point. If any refresh start is delayed past its bound, the row sequence skips, or a cycle is shortened, the RAM-side monitor reports it.

// File: rtl/sra_pkg.sv
// Shared constants and types for the shared RAM arbiter.
// Assumes a 20-bit system space, 16-bit data and 8 KiB segments.
package sra_pkg;
    localparam int SYS_AW    = 20;
    localparam int DATA_W    = 16;
    localparam int BE_W      = DATA_W / 8;
    localparam int SEG_OFF_W = 13;
    localparam int BASE_W    = SYS_AW - SEG_OFF_W;
    localparam int WORD_AW   = 15;
    localparam int SEG_IDX_W = 3;

    typedef enum logic [1:0] {
        OWN_NONE,
        OWN_REFRESH,
        OWN_LOCAL,
        OWN_BUS
    } owner_t;

    typedef struct packed {
        logic [WORD_AW-1:0] waddr;
        logic [BE_W-1:0]    be;
        logic               we;
        logic [DATA_W-1:0]  wdata;
        logic               hi_lane;
        logic               narrow;
    } ram_cmd_t;
endpackage

// File: rtl/sra_refresh_timer.sv
// Refresh scheduler: raises a pending flag every INTERVAL clocks and keeps
// the refresh row. Assumes the grant and done inputs are one-clock pulses.
module sra_refresh_timer #(
    parameter int INTERVAL = 780,
    parameter int ROW_W    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant,
    input  logic             done,
    output logic             pending,
    output logic [ROW_W-1:0] row
);
    localparam int CNT_W = $clog2(INTERVAL);

    logic [CNT_W-1:0] cnt;
    logic             tick;

    assign tick = (cnt == CNT_W'(INTERVAL - 1));

    // Interval counter, pending flag and row pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            pending <= 1'b0;
            row     <= '0;
        end else begin
            cnt <= tick ? '0 : cnt + 1'b1;
            if (tick)
                pending <= 1'b1;
            else if (grant)
                pending <= 1'b0;
            if (done)
                row <= row + 1'b1;
        end
    end
endmodule

// File: rtl/sra_bus_decode.sv
// System-bus address decode: relocatable window, segment hiding and byte-lane
// steering. Purely combinational; assumes cfg inputs are quasi-static.
module sra_bus_decode
    import sra_pkg::*;
#(
    parameter bit BIG_ARRAY = 1'b0
) (
    input  logic [SYS_AW-1:0]    bus_addr,
    input  logic                 bus_byte,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic [BASE_W-1:0]    cfg_base,
    input  logic                 cfg_prot_en,
    input  logic [SEG_IDX_W-1:0] cfg_prot_lo,
    input  logic [SEG_IDX_W-1:0] cfg_prot_hi,
    output logic                 in_window,
    output logic                 blocked,
    output ram_cmd_t             cmd
);
    localparam int NUM_SEGS = BIG_ARRAY ? 8 : 4;

    logic [BASE_W-1:0]    seg_off;
    logic [SEG_IDX_W-1:0] seg;

    // Window hit and segment protection.
    always_comb begin
        seg_off   = bus_addr[SYS_AW-1:SEG_OFF_W] - cfg_base;
        seg       = seg_off[SEG_IDX_W-1:0];
        in_window = seg_off < BASE_W'(NUM_SEGS);
        blocked   = cfg_prot_en && (seg >= cfg_prot_lo) && (seg <= cfg_prot_hi);
    end

    // RAM command with lane steering for byte transfers.
    always_comb begin
        cmd.waddr   = {seg, bus_addr[SEG_OFF_W-1:1]};
        cmd.we      = bus_we;
        cmd.narrow  = bus_byte;
        cmd.hi_lane = bus_addr[0];
        if (bus_byte) begin
            cmd.be    = bus_addr[0] ? BE_W'(2'b10) : BE_W'(2'b01);
            cmd.wdata = {BE_W{bus_wdata[7:0]}};
        end else begin
            cmd.be    = '1;
            cmd.wdata = bus_wdata;
        end
    end
endmodule

// File: rtl/sra_cycle_ctrl.sv
// RAM cycle sequencer: picks refresh, then local, then bus, only when idle,
// runs each cycle for CYCLE_CLKS clocks and acknowledges the owner after it.
// Assumes go inputs already include address decode and protection.
module sra_cycle_ctrl
    import sra_pkg::*;
#(
    parameter int CYCLE_CLKS = 3,
    parameter int ROW_W      = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              refresh_pend,
    input  logic [ROW_W-1:0]  refresh_row,
    input  logic              loc_go,
    input  ram_cmd_t          loc_cmd,
    input  logic              bus_go,
    input  ram_cmd_t          bus_cmd,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              refresh_grant,
    output logic              refresh_done,
    output owner_t            owner,
    output logic              busy,
    output ram_cmd_t          cur_cmd,
    output logic              loc_ack,
    output logic              bus_ack,
    output logic [DATA_W-1:0] loc_rdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int CNT_W = $clog2(CYCLE_CLKS + 1);

    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] bus_view;

    // Byte reads return the chosen lane in the low byte.
    always_comb begin
        if (!cur_cmd.narrow)
            bus_view = ram_rdata;
        else if (cur_cmd.hi_lane)
            bus_view = {{(DATA_W-8){1'b0}}, ram_rdata[15:8]};
        else
            bus_view = {{(DATA_W-8){1'b0}}, ram_rdata[7:0]};
    end

    // Grant at idle by fixed priority, count down, complete and acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy          <= 1'b0;
            owner         <= OWN_NONE;
            cnt           <= '0;
            cur_cmd       <= '0;
            refresh_grant <= 1'b0;
            refresh_done  <= 1'b0;
            loc_ack       <= 1'b0;
            bus_ack       <= 1'b0;
            loc_rdata     <= '0;
            bus_rdata     <= '0;
        end else begin
            refresh_grant <= 1'b0;
            refresh_done  <= 1'b0;
            loc_ack       <= 1'b0;
            bus_ack       <= 1'b0;
            if (!busy) begin
                cnt <= CNT_W'(CYCLE_CLKS - 1);
                if (refresh_pend) begin
                    busy          <= 1'b1;
                    owner         <= OWN_REFRESH;
                    cur_cmd       <= '0;
                    cur_cmd.waddr <= WORD_AW'(refresh_row);
                    refresh_grant <= 1'b1;
                end else if (loc_go) begin
                    busy    <= 1'b1;
                    owner   <= OWN_LOCAL;
                    cur_cmd <= loc_cmd;
                end else if (bus_go) begin
                    busy    <= 1'b1;
                    owner   <= OWN_BUS;
                    cur_cmd <= bus_cmd;
                end
            end else if (cnt == '0) begin
                busy  <= 1'b0;
                owner <= OWN_NONE;
                case (owner)
                    OWN_REFRESH: refresh_done <= 1'b1;
                    OWN_LOCAL: begin
                        loc_ack   <= 1'b1;
                        loc_rdata <= ram_rdata;
                    end
                    OWN_BUS: begin
                        bus_ack   <= 1'b1;
                        bus_rdata <= bus_view;
                    end
                    default: ;
                endcase
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/shared_ram_arbiter.sv
// Top: shares one DRAM array between the local processor (window at zero)
// and the system bus (relocatable window), with refresh taking precedence.
// Assumes masters hold request and address until their acknowledge clock.
module shared_ram_arbiter
    import sra_pkg::*;
#(
    parameter bit BIG_ARRAY        = 1'b0,
    parameter int REFRESH_INTERVAL = 780,
    parameter int CYCLE_CLKS       = 3,
    parameter int ROW_W            = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BASE_W-1:0]    cfg_base,
    input  logic                 cfg_prot_en,
    input  logic [SEG_IDX_W-1:0] cfg_prot_lo,
    input  logic [SEG_IDX_W-1:0] cfg_prot_hi,
    input  logic                 loc_req,
    input  logic                 loc_we,
    input  logic [SYS_AW-1:1]    loc_addr,
    input  logic [DATA_W-1:0]    loc_wdata,
    output logic [DATA_W-1:0]    loc_rdata,
    output logic                 loc_ack,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic                 bus_byte,
    input  logic [SYS_AW-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 bus_ack,
    output logic                 ram_cs,
    output logic                 ram_refresh,
    output logic                 ram_we,
    output logic [BE_W-1:0]      ram_be,
    output logic [WORD_AW-1:0]   ram_addr,
    output logic [DATA_W-1:0]    ram_wdata,
    input  logic [DATA_W-1:0]    ram_rdata
);
    localparam int RAM_AW = BIG_ARRAY ? 16 : 15;

    logic             refresh_pend, refresh_grant, refresh_done;
    logic [ROW_W-1:0] refresh_row;
    logic             loc_hit, bus_in_win, bus_blocked, bus_ok, busy;
    ram_cmd_t         loc_cmd, bus_cmd, cur_cmd;
    owner_t           cur_owner;

    // Local window is fixed at zero and spans the array.
    always_comb begin
        loc_hit       = (loc_addr[SYS_AW-1:RAM_AW] == '0);
        loc_cmd       = '0;
        loc_cmd.waddr = loc_addr[WORD_AW:1];
        loc_cmd.be    = '1;
        loc_cmd.we    = loc_we;
        loc_cmd.wdata = loc_wdata;
    end

    sra_refresh_timer #(.INTERVAL(REFRESH_INTERVAL), .ROW_W(ROW_W)) refresh_i (
        .clk(clk), .rst_n(rst_n), .grant(refresh_grant), .done(refresh_done),
        .pending(refresh_pend), .row(refresh_row)
    );

    sra_bus_decode #(.BIG_ARRAY(BIG_ARRAY)) bus_dec_i (
        .bus_addr(bus_addr), .bus_byte(bus_byte), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .cfg_base(cfg_base), .cfg_prot_en(cfg_prot_en),
        .cfg_prot_lo(cfg_prot_lo), .cfg_prot_hi(cfg_prot_hi),
        .in_window(bus_in_win), .blocked(bus_blocked), .cmd(bus_cmd)
    );

    assign bus_ok = bus_in_win && !bus_blocked;

    sra_cycle_ctrl #(.CYCLE_CLKS(CYCLE_CLKS), .ROW_W(ROW_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .refresh_pend(refresh_pend), .refresh_row(refresh_row),
        .loc_go(loc_req && loc_hit), .loc_cmd(loc_cmd),
        .bus_go(bus_req && bus_ok), .bus_cmd(bus_cmd),
        .ram_rdata(ram_rdata),
        .refresh_grant(refresh_grant), .refresh_done(refresh_done),
        .owner(cur_owner), .busy(busy), .cur_cmd(cur_cmd),
        .loc_ack(loc_ack), .bus_ack(bus_ack),
        .loc_rdata(loc_rdata), .bus_rdata(bus_rdata)
    );

    // RAM-side drive from the latched command.
    assign ram_cs      = busy;
    assign ram_refresh = busy && (cur_owner == OWN_REFRESH);
    assign ram_we      = busy && cur_cmd.we;
    assign ram_be      = busy ? cur_cmd.be : '0;
    assign ram_addr    = cur_cmd.waddr;
    assign ram_wdata   = cur_cmd.wdata;
endmodule

// File: rtl/sra_checker.sv
// Protocol checker for shared_ram_arbiter, attached by bind below.
// Assumes masters hold request and address until their acknowledge.
module sra_checker
    import sra_pkg::*;
#(
    parameter int REFRESH_INTERVAL = 780,
    parameter int CYCLE_CLKS       = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ram_cs,
    input logic            ram_refresh,
    input logic            ram_we,
    input logic [BE_W-1:0] ram_be,
    input logic            loc_req,
    input logic            loc_ack,
    input logic            loc_hit,
    input logic            bus_ack,
    input logic            bus_ok,
    input logic            refresh_pend,
    input owner_t          cur_owner
);
    int   gap_cnt;
    int   cs_len;
    logic ref_q;

    // Clocks since the last refresh start and length of the current cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= 0;
            cs_len  <= 0;
            ref_q   <= 1'b0;
        end else begin
            ref_q   <= ram_refresh;
            gap_cnt <= (ram_refresh && !ref_q) ? 0 : gap_cnt + 1;
            cs_len  <= ram_cs ? cs_len + 1 : 0;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !ram_cs && !loc_ack && !bus_ack);

    assert_refresh_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ram_refresh |-> ram_cs && !ram_we && ram_be == '0);

    assert_refresh_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        gap_cnt <= REFRESH_INTERVAL + CYCLE_CLKS + 2);

    assert_refresh_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_cs) && cur_owner != OWN_REFRESH |-> $past(!refresh_pend));

    assert_local_over_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_cs) && cur_owner == OWN_BUS |-> $past(!(loc_req && loc_hit)));

    assert_cycle_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_cs) |-> cs_len == CYCLE_CLKS);

    assert_local_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        loc_ack |-> loc_hit);

    assert_bus_allowed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> bus_ok);

    assert_data_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ram_cs && !ram_refresh |-> ram_be != '0);

    assert_ack_after_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_ack || bus_ack) |-> $past(ram_cs) && !ram_cs && !(loc_ack && bus_ack));
endmodule

bind shared_ram_arbiter sra_checker #(
    .REFRESH_INTERVAL(REFRESH_INTERVAL),
    .CYCLE_CLKS(CYCLE_CLKS)
) checker_i (
    .clk(clk), .rst_n(rst_n), .ram_cs(ram_cs), .ram_refresh(ram_refresh),
    .ram_we(ram_we), .ram_be(ram_be), .loc_req(loc_req), .loc_ack(loc_ack),
    .loc_hit(loc_hit), .bus_ack(bus_ack), .bus_ok(bus_ok),
    .refresh_pend(refresh_pend), .cur_owner(cur_owner)
);

// File: tb/shared_ram_arbiter_tb_top.sv
`timescale 1ns/1ps
module shared_ram_arbiter_tb_top;
    localparam int TB_REF   = 64;
    localparam int TB_CYC   = 3;
    localparam int MAX_WAIT = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  cfg_base = '0;
    logic        cfg_prot_en = 1'b0;
    logic [2:0]  cfg_prot_lo = '0, cfg_prot_hi = '0;
    logic        loc_req = 1'b0, loc_we = 1'b0;
    logic [19:1] loc_addr = '0;
    logic [15:0] loc_wdata = '0, loc_rdata;
    logic        loc_ack;
    logic        bus_req = 1'b0, bus_we = 1'b0, bus_byte = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic        bus_ack;
    logic        ram_cs, ram_refresh, ram_we;
    logic [1:0]  ram_be;
    logic [14:0] ram_addr;
    logic [15:0] ram_wdata, ram_rdata;

    int tests = 0, failed = 0, cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    shared_ram_arbiter #(.REFRESH_INTERVAL(TB_REF), .CYCLE_CLKS(TB_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_prot_en(cfg_prot_en),
        .cfg_prot_lo(cfg_prot_lo), .cfg_prot_hi(cfg_prot_hi),
        .loc_req(loc_req), .loc_we(loc_we), .loc_addr(loc_addr),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata), .loc_ack(loc_ack),
        .bus_req(bus_req), .bus_we(bus_we), .bus_byte(bus_byte),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .ram_cs(ram_cs), .ram_refresh(ram_refresh),
        .ram_we(ram_we), .ram_be(ram_be), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // Small RAM model indexed by a hash of the word address.
    logic [15:0] mem [0:1023];
    logic [9:0]  idx;
    assign idx       = {ram_addr[14:12], ram_addr[6:0]};
    assign ram_rdata = ram_cs ? mem[idx] : 16'h0000;
    always @(posedge clk)
        if (ram_cs && ram_we)
            mem[idx] <= {ram_be[1] ? ram_wdata[15:8] : mem[idx][15:8],
                         ram_be[0] ? ram_wdata[7:0]  : mem[idx][7:0]};

    // RAM-side monitor, sampled away from the active edge.
    logic        prev_cs = 1'b0, prev_ref = 1'b0, have_row = 1'b0;
    logic [14:0] seen_addr, last_row;
    logic [1:0]  seen_be;
    logic [15:0] seen_wdata;
    int data_starts = 0, ref_starts = 0, last_ref_t = -1;
    int len = 0, len_err = 0, gap_err = 0, row_err = 0, ack_err = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ram_cs && !prev_cs) begin
                if (ram_refresh) begin
                    if (last_ref_t >= 0 && (cyc - last_ref_t > TB_REF + TB_CYC + 2 ||
                                            cyc - last_ref_t < TB_REF - TB_CYC - 2))
                        gap_err++;
                    if (have_row && ram_addr != ((last_row + 15'd1) & 15'h7F)) row_err++;
                    last_row   = ram_addr;
                    have_row   = 1'b1;
                    last_ref_t = cyc;
                    ref_starts++;
                end else begin
                    data_starts++;
                end
            end
            if (ram_cs && !ram_refresh) begin
                seen_addr  = ram_addr;
                seen_be    = ram_be;
                seen_wdata = ram_wdata;
            end
            if (ram_cs) len++;
            else begin
                if (prev_cs && len != TB_CYC) len_err++;
                len = 0;
            end
            if ((loc_ack || bus_ack) && !(prev_cs && !prev_ref && !ram_cs)) ack_err++;
            if (loc_ack && bus_ack) ack_err++;
            prev_cs  = ram_cs;
            prev_ref = ram_refresh;
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic loc_xfer(input logic [19:0] a, input logic we, input logic [15:0] d,
                            output logic got, output logic [15:0] q, output int t);
        @(negedge clk);
        loc_addr = a[19:1]; loc_we = we; loc_wdata = d; loc_req = 1'b1;
        got = 1'b0; q = '0; t = -1;
        for (int i = 0; i < MAX_WAIT && !got; i++) begin
            @(negedge clk);
            if (loc_ack) begin got = 1'b1; q = loc_rdata; t = cyc; end
        end
        loc_req = 1'b0;
    endtask

    task automatic bus_xfer(input logic [19:0] a, input logic we, input logic nb,
                            input logic [15:0] d, output logic got,
                            output logic [15:0] q, output int t);
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_byte = nb; bus_wdata = d; bus_req = 1'b1;
        got = 1'b0; q = '0; t = -1;
        for (int i = 0; i < MAX_WAIT && !got; i++) begin
            @(negedge clk);
            if (bus_ack) begin got = 1'b1; q = bus_rdata; t = cyc; end
        end
        bus_req = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1", "ram_cs in reset", ram_cs, 0);
        chk("R1", "acks in reset", {loc_ack, bus_ack}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ram_cs after reset", ram_cs, 0);
    endtask

    task automatic t_local;
        logic g; logic [15:0] q; int t, n0;
        loc_xfer(20'h00124, 1'b1, 16'hA5A5, g, q, t);
        chk("R5", "local write ack", g, 1);
        chk("R5", "local word address", seen_addr, 15'h092);
        chk("R5", "local byte enables", seen_be, 2'b11);
        loc_xfer(20'h00124, 1'b0, 16'h0, g, q, t);
        chk("R9", "local read data", q, 16'hA5A5);
        n0 = data_starts;
        loc_xfer(20'h08000, 1'b1, 16'h1111, g, q, t);
        chk("R5", "out-of-range local ack", g, 0);
        chk("R5", "out-of-range local cycles", data_starts - n0, 0);
    endtask

    task automatic t_bus_window;
        logic g; logic [15:0] q; int t, n0;
        cfg_base = 7'h05;
        bus_xfer(20'h0A010, 1'b1, 1'b0, 16'h1234, g, q, t);
        chk("R6", "window base ack", g, 1);
        chk("R6", "window base address", seen_addr, 15'h0008);
        chk("R8", "word byte enables", seen_be, 2'b11);
        loc_xfer(20'h00010, 1'b0, 16'h0, g, q, t);
        chk("R6", "local sees bus write", q, 16'h1234);
        bus_xfer(20'h11FFE, 1'b1, 1'b0, 16'hBEEF, g, q, t);
        chk("R6", "window top address", seen_addr, 15'h3FFF);
        loc_xfer(20'h07FFE, 1'b0, 16'h0, g, q, t);
        chk("R6", "window top data", q, 16'hBEEF);
        n0 = data_starts;
        bus_xfer(20'h12000, 1'b1, 1'b0, 16'h5555, g, q, t);
        chk("R6", "above window ack", g, 0);
        bus_xfer(20'h09FFE, 1'b0, 1'b0, 16'h0, g, q, t);
        chk("R6", "below window ack", g, 0);
        chk("R6", "outside window cycles", data_starts - n0, 0);
    endtask

    task automatic t_bytes;
        logic g; logic [15:0] q; int t;
        bus_xfer(20'h0A021, 1'b1, 1'b1, 16'hEE77, g, q, t);
        chk("R8", "odd byte enables", seen_be, 2'b10);
        chk("R8", "odd byte replicated data", seen_wdata, 16'h7777);
        bus_xfer(20'h0A020, 1'b1, 1'b1, 16'hDD33, g, q, t);
        chk("R8", "even byte enables", seen_be, 2'b01);
        loc_xfer(20'h00020, 1'b0, 16'h0, g, q, t);
        chk("R8", "merged word", q, 16'h7733);
        bus_xfer(20'h0A021, 1'b0, 1'b1, 16'h0, g, q, t);
        chk("R8", "odd byte read", q, 16'h0077);
        bus_xfer(20'h0A020, 1'b0, 1'b1, 16'h0, g, q, t);
        chk("R8", "even byte read", q, 16'h0033);
        bus_xfer(20'h0A020, 1'b0, 1'b0, 16'h0, g, q, t);
        chk("R8", "word read", q, 16'h7733);
    endtask

    task automatic t_protect;
        logic g; logic [15:0] q; int t, n0;
        cfg_prot_en = 1'b1; cfg_prot_lo = 3'd1; cfg_prot_hi = 3'd2;
        n0 = data_starts;
        bus_xfer(20'h0C000, 1'b1, 1'b0, 16'h9999, g, q, t);
        chk("R7", "hidden segment 1 ack", g, 0);
        bus_xfer(20'h0E000, 1'b1, 1'b0, 16'h9999, g, q, t);
        chk("R7", "hidden segment 2 ack", g, 0);
        chk("R7", "hidden segment cycles", data_starts - n0, 0);
        bus_xfer(20'h10000, 1'b1, 1'b0, 16'h4444, g, q, t);
        chk("R7", "segment 3 open", g, 1);
        bus_xfer(20'h0A000, 1'b0, 1'b0, 16'h0, g, q, t);
        chk("R7", "segment 0 open", g, 1);
        cfg_prot_en = 1'b0;
        bus_xfer(20'h0C000, 1'b1, 1'b0, 16'h9999, g, q, t);
        chk("R7", "protection disabled ack", g, 1);
    endtask

    task automatic t_priority;
        logic gl, gb; logic [15:0] ql, qb; int tl, tb;
        fork
            loc_xfer(20'h00010, 1'b0, 16'h0, gl, ql, tl);
            bus_xfer(20'h0A020, 1'b0, 1'b0, 16'h0, gb, qb, tb);
        join
        chk("R4", "both served", {gl, gb}, 2'b11);
        chk("R4", "local before bus", (tl < tb), 1);
        chk("R4", "local data under contention", ql, 16'h1234);
    endtask

    task automatic t_refresh_stress;
        int r0, nl, nb;
        r0 = ref_starts; nl = 0; nb = 0;
        fork
            for (int i = 0; i < 24; i++) begin
                logic g; logic [15:0] q; int t;
                loc_xfer(20'h00100 + 20'(2 * i), 1'b1, 16'(i), g, q, t);
                if (g) nl++;
            end
            for (int i = 0; i < 24; i++) begin
                logic g; logic [15:0] q; int t;
                bus_xfer(20'h0A200 + 20'(2 * i), 1'b1, 1'b0, 16'(i), g, q, t);
                if (g) nb++;
            end
        join
        chk("R2", "refreshes during stress >= 2", (ref_starts - r0 >= 2), 1);
        chk("R2", "refresh start spacing errors", gap_err, 0);
        chk("R3", "refresh row sequence errors", row_err, 0);
        chk("R4", "stress transfers served", nl + nb, 48);
        chk("R4", "cycle length errors", len_err, 0);
        chk("R9", "acknowledge timing errors", ack_err, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failed++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        t_reset();
        t_local();
        t_bus_window();
        t_bytes();
        t_protect();
        t_priority();
        t_refresh_stress();
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule